// File: doc/BRIEF.md
# I2C SCL Rate Generator

This block produces the serial clock of an I2C master from a reference clock. It never drives the line high. It either pulls SCL low or lets it go, so the output is suitable for an open-drain pad. The phase lengths come from an 8-bit rate setting. In standard and fast modes the low and high phases are equal. In high-speed mode a separate low count makes the period asymmetric. The block reads the real line level back through a two-flop synchroniser. It only starts counting the high phase once the line is seen high, so slave clock stretching and the bus rise time are both absorbed in that wait. A watchdog on the synchronised line raises a sticky flag when SCL stays low too long. While the flag is set the drive is released. Single-cycle strobes tell a byte engine when to change data and when to sample it.

The controller is a four-state machine:
- `ST_IDLE`: released.
- `ST_LOW`: driving low and counting.
- `ST_WAIT_HI`: released, waiting for the line to read high.
- `ST_HIGH`: released and counting.

The transitions are:
- idle-to-low: enable is set and no timeout is pending.
- low-to-wait: the low count expired and enable is still set.
- low-to-idle: the low count expired with enable clear, or a timeout occurred.
- wait-to-high: the line is sampled high.
- wait-to-idle: enable dropped or a timeout occurred.
- high-to-low: the high count expired and enable is still set.
- high-to-idle: the high count expired with enable clear, or a timeout occurred.

A configuration is offered as three signed requested values plus a mode bit. It is checked before it is accepted.

Top module: `i2c_scl_gen`

## Requirements
- R1: With `cfg_hs`=0, every driven-low phase lasts `baud`+5 reference cycles. Every counted high phase (from the rise strobe to the next fall strobe) also lasts `baud`+5 cycles.
- R2: On `cfg_load`, if any of the three requested values is below 0 or above 255, `cfg_err` is high for exactly the next cycle and the active configuration keeps its previous values.
- R3: With `cfg_hs`=1 and a nonzero low value L, the low phase lasts L+1 cycles. The high phase lasts H+1 cycles, where H is the high value.
- R4: With `cfg_hs`=1 and L=0, both phases last H+1 cycles.
- R5: After the drive is released, the high phase does not begin while the line reads low. `rise_stb` appears on the third cycle after the line returns high (two synchroniser flops plus the state register).
- R6: `baud`=0 gives a steady 5-cycle low and 5-cycle high waveform without lockup.
- R7: When the synchronised line stays low for `tmo_limit`×16 cycles, `tmo_flag` is set. A `tmo_limit` of 0 disables the timeout.
- R8: `tmo_flag` stays set until a `tmo_clr` pulse. The cycle after the flag is seen, the drive is released and stays released while the flag is set. Generation resumes after the clear.
- R9: `fall_stb` is high for one cycle, on the first cycle of each driven-low phase. `rise_stb` is high for one cycle, on the first counted high cycle.
- R10: From the released state, setting `enable` drives SCL low on the next cycle. With `enable` clear, no new low phase starts once the current phase ends.
- R11: After reset, SCL is released, all strobes and flags are low, and the active configuration is standard mode with `baud`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run SCL generation |
| cfg_load | input | 1 | Pulse: validate and apply the requested configuration |
| cfg_hs | input | 1 | 1 selects high-speed phase timing |
| cfg_baud | input | REQ_W | Signed requested symmetric rate value |
| cfg_low_hs | input | REQ_W | Signed requested high-speed low count |
| cfg_high_hs | input | REQ_W | Signed requested high-speed high count |
| tmo_limit | input | TMO_W | Stuck-low limit in units of 16 cycles, 0 disables |
| tmo_clr | input | 1 | Pulse: clear the timeout flag |
| scl_in | input | 1 | Level read back from the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| fall_stb | output | 1 | Data-change strobe at the SCL falling edge |
| rise_stb | output | 1 | Data-sample strobe at the sampled rising edge |
| tmo_flag | output | 1 | Sticky stuck-low flag |
| cfg_err | output | 1 | Configuration rejected, one-cycle pulse |

## Verification
- **Configuration:** `cfg_err` and the new active values appear one cycle after the load pulse.
- **Start and strobes:** `fall_stb` and the low drive appear one cycle after `enable` is seen in the idle state. `rise_stb` follows the line going high by three cycles.
- **Timeout:** the flag is set one cycle after the prescaled count reaches the limit, and the drive is released one cycle after that.
- **Method:** stimulus is applied on falling clock edges. A behavioural model advances on the same rising edges as the design and is compared with every output on each falling edge, so no result is read before its due cycle. The phase-length checks count whole cycles between strobes.

// File: rtl/scl_pkg.sv
package scl_pkg;
    localparam int BAUD_W  = 8;
    localparam int PHASE_W = BAUD_W + 1;
    localparam int SYM_OVH = 5;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOW     = 2'd1,
        ST_WAIT_HI = 2'd2,
        ST_HIGH    = 2'd3
    } phase_e;

    typedef struct packed {
        logic              hs;
        logic [BAUD_W-1:0] baud;
        logic [BAUD_W-1:0] low_hs;
        logic [BAUD_W-1:0] high_hs;
    } scl_cfg_t;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '1;
        else        shreg <= {shreg[STAGES-2:0], d};
    end

    assign q = shreg[STAGES-1];
endmodule

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
    import scl_pkg::*;
#(
    parameter int REQ_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    hs,
    input  logic signed [REQ_W-1:0] req_baud,
    input  logic signed [REQ_W-1:0] req_low,
    input  logic signed [REQ_W-1:0] req_high,
    output scl_cfg_t                cfg,
    output logic                    err
);
    localparam int NREQ = 3;
    localparam logic signed [REQ_W-1:0] MAXV = REQ_W'((1 << BAUD_W) - 1);

    logic signed [REQ_W-1:0] reqs [NREQ];
    logic [NREQ-1:0]         ok;

    assign reqs[0] = req_baud;
    assign reqs[1] = req_low;
    assign reqs[2] = req_high;

    for (genvar i = 0; i < NREQ; i++) begin : g_chk
        assign ok[i] = (reqs[i] >= 0) && (reqs[i] <= MAXV);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
            err <= 1'b0;
        end else begin
            err <= 1'b0;
            if (load) begin
                if (&ok) begin
                    cfg.hs      <= hs;
                    cfg.baud    <= req_baud[BAUD_W-1:0];
                    cfg.low_hs  <= req_low[BAUD_W-1:0];
                    cfg.high_hs <= req_high[BAUD_W-1:0];
                end else begin
                    err <= 1'b1;
                end
            end
        end
    end

    AST_CFG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $stable(cfg)); // R2
endmodule

// File: rtl/scl_timeout.sv
module scl_timeout #(
    parameter int TMO_PRESC = 16,
    parameter int TMO_W     = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_hi,
    input  logic [TMO_W-1:0] limit,
    input  logic             clr,
    output logic             flag
);
    localparam int PRESC_W = $clog2(TMO_PRESC);

    logic [PRESC_W-1:0] pre_cnt;
    logic [TMO_W-1:0]   tick_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            tick_cnt <= '0;
        end else if (clr || scl_hi) begin
            pre_cnt  <= '0;
            tick_cnt <= '0;
        end else if (pre_cnt == PRESC_W'(TMO_PRESC - 1)) begin
            pre_cnt  <= '0;
            if (tick_cnt != '1) tick_cnt <= tick_cnt + TMO_W'(1);
        end else begin
            pre_cnt <= pre_cnt + PRESC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                           flag <= 1'b0;
        else if (clr)                                         flag <= 1'b0;
        else if (!scl_hi && (limit != '0) && (tick_cnt >= limit)) flag <= 1'b1;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clr |=> flag); // R8
    AST_FLAG_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> !$past(scl_hi)); // R7
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_pkg::*;
#(
    parameter int HS_EN = 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable,
    input  logic     tmo_flag,
    input  logic     scl_hi,
    input  scl_cfg_t cfg,
    output logic     drive_low,
    output logic     fall_stb,
    output logic     rise_stb
);
    phase_e             st, st_n;
    logic [PHASE_W-1:0] cnt, cnt_n;
    logic [PHASE_W-1:0] low_len, high_len;
    logic [PHASE_W-1:0] sym_len;

    assign sym_len = PHASE_W'(cfg.baud) + PHASE_W'(SYM_OVH);

    if (HS_EN != 0) begin : g_hs
        logic [PHASE_W-1:0] hs_hi, hs_lo;
        assign hs_hi    = PHASE_W'(cfg.high_hs) + PHASE_W'(1);
        assign hs_lo    = (cfg.low_hs == '0) ? hs_hi : PHASE_W'(cfg.low_hs) + PHASE_W'(1);
        assign low_len  = cfg.hs ? hs_lo : sym_len;
        assign high_len = cfg.hs ? hs_hi : sym_len;
    end else begin : g_sym
        assign low_len  = sym_len;
        assign high_len = sym_len;
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        unique case (st)
            ST_IDLE: begin
                if (enable && !tmo_flag) begin
                    st_n  = ST_LOW;
                    cnt_n = low_len - PHASE_W'(1);
                end
            end
            ST_LOW: begin
                if (tmo_flag)          st_n = ST_IDLE;
                else if (cnt == '0)    st_n = enable ? ST_WAIT_HI : ST_IDLE;
                else                   cnt_n = cnt - PHASE_W'(1);
            end
            ST_WAIT_HI: begin
                if (tmo_flag || !enable) begin
                    st_n = ST_IDLE;
                end else if (scl_hi) begin
                    st_n  = ST_HIGH;
                    cnt_n = high_len - PHASE_W'(1);
                end
            end
            ST_HIGH: begin
                if (tmo_flag) begin
                    st_n = ST_IDLE;
                end else if (cnt == '0) begin
                    if (enable) begin
                        st_n  = ST_LOW;
                        cnt_n = low_len - PHASE_W'(1);
                    end else begin
                        st_n = ST_IDLE;
                    end
                end else begin
                    cnt_n = cnt - PHASE_W'(1);
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_low <= 1'b0;
            fall_stb  <= 1'b0;
            rise_stb  <= 1'b0;
        end else begin
            drive_low <= (st_n == ST_LOW);
            fall_stb  <= (st_n == ST_LOW)  && (st != ST_LOW);
            rise_stb  <= (st_n == ST_HIGH) && (st != ST_HIGH);
        end
    end

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !fall_stb); // R9
    AST_RISE_SAMPLED: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> $past(scl_hi)); // R5
    AST_RELEASE_ON_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_flag |=> !drive_low); // R8
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable && !drive_low |=> !drive_low); // R10
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
    import scl_pkg::*;
#(
    parameter int REQ_W       = 12,
    parameter int TMO_PRESC   = 16,
    parameter int TMO_W       = 12,
    parameter int SYNC_STAGES = 2,
    parameter int HS_EN       = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic                    cfg_load,
    input  logic                    cfg_hs,
    input  logic signed [REQ_W-1:0] cfg_baud,
    input  logic signed [REQ_W-1:0] cfg_low_hs,
    input  logic signed [REQ_W-1:0] cfg_high_hs,
    input  logic [TMO_W-1:0]        tmo_limit,
    input  logic                    tmo_clr,
    input  logic                    scl_in,
    output logic                    scl_drive_low,
    output logic                    fall_stb,
    output logic                    rise_stb,
    output logic                    tmo_flag,
    output logic                    cfg_err
);
    scl_cfg_t act_cfg;
    logic     scl_hi;

    scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (scl_in),
        .q     (scl_hi)
    );

    scl_cfg_regs #(.REQ_W(REQ_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .hs       (cfg_hs),
        .req_baud (cfg_baud),
        .req_low  (cfg_low_hs),
        .req_high (cfg_high_hs),
        .cfg      (act_cfg),
        .err      (cfg_err)
    );

    scl_timeout #(.TMO_PRESC(TMO_PRESC), .TMO_W(TMO_W)) u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_hi (scl_hi),
        .limit  (tmo_limit),
        .clr    (tmo_clr),
        .flag   (tmo_flag)
    );

    scl_phase_fsm #(.HS_EN(HS_EN)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tmo_flag  (tmo_flag),
        .scl_hi    (scl_hi),
        .cfg       (act_cfg),
        .drive_low (scl_drive_low),
        .fall_stb  (fall_stb),
        .rise_stb  (rise_stb)
    );
endmodule

// File: tb/tb_i2c_scl_gen.sv
module tb_i2c_scl_gen;
    localparam int CLK_PERIOD = 10;
    localparam int REQ_W = 12;
    localparam int TMO_W = 12;
    localparam int PRESC = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, cfg_load = 1'b0, cfg_hs = 1'b0, tmo_clr = 1'b0;
    logic signed [REQ_W-1:0] cfg_baud = '0, cfg_low_hs = '0, cfg_high_hs = '0;
    logic [TMO_W-1:0] tmo_limit = '0;
    logic hold = 1'b0;
    logic scl_line;
    logic scl_drive_low, fall_stb, rise_stb, tmo_flag, cfg_err;

    int checks = 0;
    int errors = 0;
    string cur_req = "R11";

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_line = !scl_drive_low && !hold;

    i2c_scl_gen dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_load(cfg_load),
        .cfg_hs(cfg_hs), .cfg_baud(cfg_baud), .cfg_low_hs(cfg_low_hs),
        .cfg_high_hs(cfg_high_hs), .tmo_limit(tmo_limit), .tmo_clr(tmo_clr),
        .scl_in(scl_line), .scl_drive_low(scl_drive_low), .fall_stb(fall_stb),
        .rise_stb(rise_stb), .tmo_flag(tmo_flag), .cfg_err(cfg_err)
    );

    // Behavioural reference model: 0 idle, 1 low, 2 wait, 3 high
    int m_st, m_cnt, m_pc, m_tc;
    bit m_s1, m_s2, m_flag, m_drv, m_fall, m_rise, m_err;
    int c_hs, c_baud, c_lo, c_hi;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_pc = 0; m_tc = 0;
            m_s1 = 1; m_s2 = 1; m_flag = 0;
            m_drv = 0; m_fall = 0; m_rise = 0; m_err = 0;
            c_hs = 0; c_baud = 0; c_lo = 0; c_hi = 0;
        end else begin
            bit line, hi, n_flag, n_err;
            int n_st, n_cnt, lo_len, hi_len, b, l, h;
            line = !m_drv && !hold;
            hi = m_s2;
            n_flag = m_flag;
            if (tmo_clr) n_flag = 0;
            else if (!hi && tmo_limit != 0 && m_tc >= int'(tmo_limit)) n_flag = 1;
            if (tmo_clr || hi) begin m_pc = 0; m_tc = 0; end
            else if (m_pc == PRESC - 1) begin
                m_pc = 0;
                if (m_tc < (1 << TMO_W) - 1) m_tc = m_tc + 1;
            end else m_pc = m_pc + 1;
            if (c_hs != 0) begin
                hi_len = c_hi + 1;
                lo_len = (c_lo == 0) ? hi_len : c_lo + 1;
            end else begin
                lo_len = c_baud + 5;
                hi_len = c_baud + 5;
            end
            n_st = m_st; n_cnt = m_cnt;
            case (m_st)
                0: if (enable && !m_flag) begin n_st = 1; n_cnt = lo_len - 1; end
                1: if (m_flag) n_st = 0;
                   else if (m_cnt == 0) n_st = enable ? 2 : 0;
                   else n_cnt = m_cnt - 1;
                2: if (m_flag || !enable) n_st = 0;
                   else if (hi) begin n_st = 3; n_cnt = hi_len - 1; end
                default: if (m_flag) n_st = 0;
                   else if (m_cnt == 0) begin
                       if (enable) begin n_st = 1; n_cnt = lo_len - 1; end
                       else n_st = 0;
                   end else n_cnt = m_cnt - 1;
            endcase
            n_err = 0;
            if (cfg_load) begin
                b = int'(cfg_baud); l = int'(cfg_low_hs); h = int'(cfg_high_hs);
                if (b < 0 || b > 255 || l < 0 || l > 255 || h < 0 || h > 255) n_err = 1;
                else begin c_hs = int'(cfg_hs); c_baud = b; c_lo = l; c_hi = h; end
            end
            m_fall = (n_st == 1) && (m_st != 1);
            m_rise = (n_st == 3) && (m_st != 3);
            m_drv = (n_st == 1);
            m_err = n_err;
            m_flag = n_flag;
            m_s2 = m_s1; m_s1 = line;
            m_st = n_st; m_cnt = n_cnt;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n)
            chk(cur_req, "cycle compare {drv,fall,rise,flag,err}",
                int'({scl_drive_low, fall_stb, rise_stb, tmo_flag, cfg_err}),
                int'({m_drv, m_fall, m_rise, m_flag, m_err}));
    end

    task automatic load_cfg(input bit hs, input int b, input int l, input int h);
        @(negedge clk);
        cfg_load = 1; cfg_hs = hs;
        cfg_baud = REQ_W'(b); cfg_low_hs = REQ_W'(l); cfg_high_hs = REQ_W'(h);
        @(negedge clk);
        cfg_load = 0;
    endtask

    task automatic wait_fall();
        @(negedge clk);
        while (!fall_stb) @(negedge clk);
    endtask

    task automatic meas_low(input string req, input int exp);
        int n = 0;
        wait_fall();
        while (scl_drive_low) begin n++; @(negedge clk); end
        chk(req, "low phase length", n, exp);
    endtask

    task automatic meas_high(input string req, input int exp);
        int n = 0;
        @(negedge clk);
        while (!rise_stb) @(negedge clk);
        do begin n++; @(negedge clk); end while (!fall_stb);
        chk(req, "high phase length", n, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog act=timeout exp=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        chk("R11", "reset outputs", int'({scl_drive_low, fall_stb, rise_stb, tmo_flag, cfg_err}), 0);

        // R10 / R9: start from released state
        cur_req = "R10";
        enable = 1;
        @(negedge clk);
        chk("R10", "drive one cycle after enable", int'(scl_drive_low), 1);
        chk("R9", "fall strobe on first low cycle", int'(fall_stb), 1);
        @(negedge clk);
        chk("R9", "fall strobe single cycle", int'(fall_stb), 0);

        // R6: baud zero
        cur_req = "R6";
        meas_low("R6", 5);
        meas_high("R6", 5);

        // R1: symmetric phases
        cur_req = "R1";
        load_cfg(0, 20, 0, 0);
        chk("R1", "valid load no error", int'(cfg_err), 0);
        meas_low("R1", 25);
        meas_high("R1", 25);

        // R2: rejected configurations
        cur_req = "R2";
        load_cfg(0, 300, 0, 0);
        chk("R2", "error on 300", int'(cfg_err), 1);
        @(negedge clk);
        chk("R2", "error is one cycle", int'(cfg_err), 0);
        load_cfg(1, 10, -3, 5);
        chk("R2", "error on negative", int'(cfg_err), 1);
        meas_low("R2", 25);
        meas_high("R2", 25);

        // R3: asymmetric high-speed
        cur_req = "R3";
        load_cfg(1, 0, 6, 2);
        meas_low("R3", 7);
        meas_high("R3", 3);

        // R4: symmetric fallback
        cur_req = "R4";
        load_cfg(1, 0, 0, 4);
        meas_low("R4", 5);
        meas_high("R4", 5);

        // R5: stretching
        cur_req = "R5";
        load_cfg(0, 10, 0, 0);
        wait_fall();
        hold = 1;
        begin
            int seen = 0;
            repeat (40) begin @(negedge clk); if (rise_stb) seen++; end
            chk("R5", "no rise while held low", seen, 0);
        end
        hold = 0;
        @(negedge clk); chk("R5", "rise not at +1", int'(rise_stb), 0);
        @(negedge clk); chk("R5", "rise not at +2", int'(rise_stb), 0);
        @(negedge clk); chk("R5", "rise at +3", int'(rise_stb), 1);
        chk("R9", "drive released at rise", int'(scl_drive_low), 0);

        // R10: enable off
        cur_req = "R10";
        @(negedge clk);
        while (!rise_stb) @(negedge clk);
        enable = 0;
        begin
            int drv = 0;
            repeat (300) begin @(negedge clk); if (scl_drive_low || fall_stb) drv++; end
            chk("R10", "no drive after disable", drv, 0);
        end
        enable = 1;
        @(negedge clk);
        chk("R10", "restart drive", int'(scl_drive_low), 1);

        // R7 / R8: timeout
        cur_req = "R7";
        tmo_limit = TMO_W'(3);
        meas_low("R7", 15);
        hold = 1;
        repeat (80) @(negedge clk);
        chk("R7", "flag after stuck low", int'(tmo_flag), 1);
        cur_req = "R8";
        chk("R8", "drive released with flag", int'(scl_drive_low), 0);
        hold = 0;
        repeat (10) @(negedge clk);
        chk("R8", "flag sticky", int'(tmo_flag), 1);
        chk("R8", "still released", int'(scl_drive_low), 0);
        tmo_clr = 1;
        @(negedge clk);
        tmo_clr = 0;
        chk("R8", "flag cleared", int'(tmo_flag), 0);
        wait_fall();
        chk("R8", "resumes after clear", int'(scl_drive_low), 1);

        // R7: disabled timeout
        cur_req = "R7";
        tmo_limit = '0;
        hold = 1;
        repeat (300) @(negedge clk);
        chk("R7", "limit zero never flags", int'(tmo_flag), 0);
        hold = 0;
        meas_low("R7", 15);

        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule